// File: doc/BRIEF.md
# Compare-and-Branch Resolver with Static Prediction

This block settles the conditional branches of a stack machine that compare two signed words and jump on the result. A start strobe presents one decoded 3-byte branch: the opcode fields (condition, A-operand source, static prediction bit, byte-compare form), the first operand byte (alpha), the displacement byte (beta), the current PC, the stack top and a B operand already fetched. One cycle later the block presents the branch target, whether the branch is taken, whether the front end must be redirected, the penalty in cycles, and the change to the stack pointer.

The opcode's static prediction bit says which way the fetch unit has already gone. When the resolved direction disagrees, the block asks for a redirect and charges a fixed penalty. Four saturating counters sort every resolved branch into good jumps, bad jumps, good fall-throughs and bad fall-throughs.

Top module: `branchResolver`

## Requirements
- R1: After reset, `resValid`, `taken`, `redirect`, `penalty`, `target`, `stackDelta` and all four counters are zero.
- R2: `condSel` picks the test of A against B as signed 32-bit values: 0 equal, 1 greater, 2 greater-or-equal, 3 less, 4 less-or-equal, 5 not-equal. Codes 6 and 7 are never taken.
- R3: With `byteCmp` low, `aSel` picks A: 0 the constant 0, 1 the constant 1, 2 the stack top, 3 the stack top with a pop. B is `bOperand`.
- R4: With `byteCmp` high, A is the stack top and B is `alpha` zero-extended to 32 bits, whatever `aSel` holds. `condSel` still chooses the test.
- R5: `target` equals `thisPc` plus `beta` sign-extended (bytes above 127 are negative), wrapping modulo 2^32.
- R6: `redirect` is 1 exactly when `taken` differs from the prediction bit given with the start strobe.
- R7: `penalty` is 3 when `redirect` is 1 and 0 otherwise.
- R8: Each resolved branch adds one to exactly one counter. Predicted taken and taken counts in `goodJumps`. Predicted taken and not taken counts in `badJumps`. Predicted not taken and not taken counts in `goodFalls`. Predicted not taken and taken counts in `badFalls`.
- R9: A counter at its maximum value (all ones, CNT_W bits) stays there.
- R10: `resValid` is high for the one cycle after each cycle in which `start` is high. Result outputs and counters change only on that edge and hold their values until the next start.
- R11: `stackDelta` is 2'b11 (minus one) for a pop (`aSel`=3 or `byteCmp`=1), otherwise 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Resolve the branch on the inputs this cycle |
| byteCmp | input | 1 | Stack top against immediate byte form |
| condSel | input | 3 | Comparison condition code |
| aSel | input | 2 | A operand source |
| predictTaken | input | 1 | Static prediction bit of the opcode |
| stackTop | input | 32 | Current stack top word |
| bOperand | input | 32 | B operand word |
| alpha | input | 8 | First operand byte |
| beta | input | 8 | Signed displacement byte |
| thisPc | input | 32 | PC of the branch |
| resValid | output | 1 | Result valid strobe |
| taken | output | 1 | Condition held |
| redirect | output | 1 | Prediction was wrong, refetch needed |
| penalty | output | 2 | Extra cycles charged |
| target | output | 32 | Branch target PC |
| stackDelta | output | 2 | Stack pointer change, two's complement |
| goodJumps | output | 32 | Count of correctly predicted taken branches |
| badJumps | output | 32 | Count of predicted-taken branches that fell through |
| goodFalls | output | 32 | Count of correctly predicted fall-throughs |
| badFalls | output | 32 | Count of predicted-not-taken branches that were taken |

## Verification
The assertions check on every cycle that a result follows each start by exactly one cycle, that the redirect matches the mismatch between the outcome and the recorded prediction, that the penalty tracks the redirect, and that counters never drop and never wrap. Only the bench's scenarios can show that each condition code gives the right signed result, that operand selection and the byte-compare zero extension pick the right values, that the displacement sign-extends, and that each outcome lands in the correct counter.

// File: rtl/brPkg.sv
package brPkg;
  typedef enum logic [2:0] {
    CondEq = 3'd0, CondGt = 3'd1, CondGe = 3'd2,
    CondLt = 3'd3, CondLe = 3'd4, CondNe = 3'd5
  } condCode_e;

  typedef enum logic [1:0] {
    SrcZero = 2'd0, SrcOne = 2'd1, SrcTop = 2'd2, SrcTopPop = 2'd3
  } aSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic redirect;
  } ctlStrobes_t;

  localparam int unsigned NumCounters = 4;
  localparam int unsigned IdxGoodJump = 0;
  localparam int unsigned IdxBadJump  = 1;
  localparam int unsigned IdxGoodFall = 2;
  localparam int unsigned IdxBadFall  = 3;
endpackage

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned DISP_W  = 8,
  parameter int unsigned IMM_W   = 8,
  parameter int unsigned PENALTY = 3,
  localparam int unsigned PEN_W  = $clog2(PENALTY + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              byteCmp,
  input  logic [2:0]        condSel,
  input  logic [1:0]        aSel,
  input  logic [DATA_W-1:0] stackTop,
  input  logic [DATA_W-1:0] bOperand,
  input  logic [IMM_W-1:0]  alpha,
  input  logic [DISP_W-1:0] beta,
  input  logic [PC_W-1:0]   thisPc,
  output logic              takenNow,
  output logic              takenQ,
  output logic              redirectQ,
  output logic [PEN_W-1:0]  penaltyQ,
  output logic [PC_W-1:0]   targetQ,
  output logic [1:0]        deltaQ
);
  logic [DATA_W-1:0] aVal, bVal;
  logic              isEq, isLt, popNow;
  logic [PC_W-1:0]   dispExt;

  always_comb begin
    if (byteCmp) begin
      aVal = stackTop;
      bVal = {{(DATA_W-IMM_W){1'b0}}, alpha};
    end else begin
      bVal = bOperand;
      case (aSrc_e'(aSel))
        SrcZero: aVal = '0;
        SrcOne:  aVal = {{(DATA_W-1){1'b0}}, 1'b1};
        default: aVal = stackTop;
      endcase
    end
  end

  assign isEq   = (aVal == bVal);
  assign isLt   = ($signed(aVal) < $signed(bVal));
  assign popNow = byteCmp || (aSel == SrcTopPop);

  always_comb begin
    case (condSel)
      CondEq:  takenNow = isEq;
      CondGt:  takenNow = !isEq && !isLt;
      CondGe:  takenNow = !isLt;
      CondLt:  takenNow = isLt;
      CondLe:  takenNow = isLt || isEq;
      CondNe:  takenNow = !isEq;
      default: takenNow = 1'b0;
    endcase
  end

  assign dispExt = {{(PC_W-DISP_W){beta[DISP_W-1]}}, beta};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenQ    <= 1'b0;
      redirectQ <= 1'b0;
      penaltyQ  <= '0;
      targetQ   <= '0;
      deltaQ    <= 2'b00;
    end else if (ctl.load) begin
      takenQ    <= takenNow;
      redirectQ <= ctl.redirect;
      penaltyQ  <= ctl.redirect ? PEN_W'(PENALTY) : '0;
      targetQ   <= thisPc + dispExt;
      deltaQ    <= popNow ? 2'b11 : 2'b00;
    end
  end

  // R10: registered results hold between loads
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(takenQ) && $stable(targetQ) && $stable(deltaQ)));
  // R11: delta only ever zero or minus one
  a_r11_delta_legal: assert property (@(posedge clk) disable iff (!rstN)
    (deltaQ == 2'b00) || (deltaQ == 2'b11));
endmodule

// File: rtl/brControl.sv
module brControl
  import brPkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             predictTaken,
  input  logic             takenNow,
  output ctlStrobes_t      ctl,
  output logic             validQ,
  output logic [CNT_W-1:0] goodJumps,
  output logic [CNT_W-1:0] badJumps,
  output logic [CNT_W-1:0] goodFalls,
  output logic [CNT_W-1:0] badFalls
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [NumCounters-1:0] bump;
  logic [CNT_W-1:0]       cnt [NumCounters];

  assign ctl.load     = start;
  assign ctl.redirect = start && (takenNow != predictTaken);

  always_comb begin
    bump = '0;
    if (start) begin
      if (predictTaken) bump[takenNow ? IdxGoodJump : IdxBadJump] = 1'b1;
      else              bump[takenNow ? IdxBadFall  : IdxGoodFall] = 1'b1;
    end
  end

  for (genvar i = 0; i < NumCounters; i++) begin : gCnt
    always_ff @(posedge clk) begin
      if (!rstN)                          cnt[i] <= '0;
      else if (bump[i] && cnt[i] != CntMax) cnt[i] <= cnt[i] + 1'b1;
    end
    // R9: saturated counter stays saturated
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[i] == CntMax) |=> (cnt[i] == CntMax));
    // R8: counters only step up by one or hold
    a_r8_monotone: assert property (@(posedge clk) disable iff (!rstN)
      ##1 ((cnt[i] == $past(cnt[i])) || (cnt[i] == $past(cnt[i]) + 1'b1)));
  end

  assign goodJumps = cnt[IdxGoodJump];
  assign badJumps  = cnt[IdxBadJump];
  assign goodFalls = cnt[IdxGoodFall];
  assign badFalls  = cnt[IdxBadFall];

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= start;
  end

  // R10: valid exactly one cycle after start
  a_r10_valid_after_start: assert property (@(posedge clk) disable iff (!rstN)
    start |=> validQ);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !validQ);
  // R8: at most one counter moves per resolved branch
  a_r8_one_bump: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bump));
endmodule

// File: rtl/branchResolver.sv
module branchResolver
  import brPkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PENALTY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              byteCmp,
  input  logic [2:0]        condSel,
  input  logic [1:0]        aSel,
  input  logic              predictTaken,
  input  logic [DATA_W-1:0] stackTop,
  input  logic [DATA_W-1:0] bOperand,
  input  logic [7:0]        alpha,
  input  logic [7:0]        beta,
  input  logic [PC_W-1:0]   thisPc,
  output logic              resValid,
  output logic              taken,
  output logic              redirect,
  output logic [1:0]        penalty,
  output logic [PC_W-1:0]   target,
  output logic [1:0]        stackDelta,
  output logic [CNT_W-1:0]  goodJumps,
  output logic [CNT_W-1:0]  badJumps,
  output logic [CNT_W-1:0]  goodFalls,
  output logic [CNT_W-1:0]  badFalls
);
  ctlStrobes_t ctl;
  logic        takenNow;

  brControl #(.CNT_W(CNT_W)) control_i (
    .clk, .rstN, .start, .predictTaken, .takenNow, .ctl,
    .validQ(resValid), .goodJumps, .badJumps, .goodFalls, .badFalls
  );

  brDatapath #(.DATA_W(DATA_W), .PC_W(PC_W), .DISP_W(8), .IMM_W(8),
               .PENALTY(PENALTY)) datapath_i (
    .clk, .rstN, .ctl, .byteCmp, .condSel, .aSel, .stackTop, .bOperand,
    .alpha, .beta, .thisPc, .takenNow, .takenQ(taken), .redirectQ(redirect),
    .penaltyQ(penalty), .targetQ(target), .deltaQ(stackDelta)
  );

  // R6: redirect flags disagreement between outcome and prediction
  a_r6_redirect_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (redirect == (taken != $past(predictTaken))));
  // R7: penalty follows redirect
  a_r7_penalty_on_redirect: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (penalty == 2'(PENALTY)));
  a_r7_no_penalty: assert property (@(posedge clk) disable iff (!rstN)
    !redirect |-> (penalty == 2'd0));
endmodule

// File: tb/branchResolver_tb.sv
module branchResolver_tb_top;
  localparam int CW = 3;

  typedef struct packed {
    logic        byteCmp;
    logic [2:0]  cond;
    logic [1:0]  src;
    logic        pred;
    logic [31:0] top;
    logic [31:0] bOp;
    logic [7:0]  alpha;
    logic [7:0]  beta;
    logic [31:0] pc;
    logic        expTaken;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 2'd2, 1'b1, 32'd5,        32'd5,        8'h00, 8'h10, 32'd100,    1'b1},
    '{1'b0, 3'd1, 2'd3, 1'b0, 32'hFFFFFFFF, 32'd1,        8'h00, 8'h04, 32'd200,    1'b0},
    '{1'b0, 3'd2, 2'd0, 1'b0, 32'd99,       32'd0,        8'h00, 8'h7F, 32'd300,    1'b1},
    '{1'b0, 3'd3, 2'd1, 1'b1, 32'd0,        32'd2,        8'h00, 8'hFF, 32'd400,    1'b1},
    '{1'b0, 3'd4, 2'd2, 1'b1, 32'd7,        32'hFFFFFFFD, 8'h00, 8'h01, 32'd500,    1'b0},
    '{1'b0, 3'd5, 2'd2, 1'b0, 32'd4,        32'd4,        8'h00, 8'h02, 32'd600,    1'b0},
    '{1'b0, 3'd6, 2'd2, 1'b0, 32'd1,        32'd0,        8'h00, 8'h03, 32'd700,    1'b0},
    '{1'b1, 3'd0, 2'd0, 1'b1, 32'h000000C8, 32'd0,        8'hC8, 8'hF0, 32'h200,    1'b1},
    '{1'b1, 3'd5, 2'd1, 1'b0, 32'hFFFFFFC8, 32'hFFFFFFC8, 8'hC8, 8'h08, 32'h300,    1'b1},
    '{1'b0, 3'd4, 2'd3, 1'b0, 32'hFFFFFFFB, 32'hFFFFFFFB, 8'h00, 8'h20, 32'h400,    1'b1},
    '{1'b0, 3'd2, 2'd2, 1'b1, 32'hFFFFFFFA, 32'hFFFFFFFB, 8'h00, 8'h40, 32'h500,    1'b0},
    '{1'b0, 3'd1, 2'd2, 1'b1, 32'h7FFFFFFF, 32'h80000000, 8'h00, 8'h80, 32'h0,      1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic byteCmp = 1'b0, predictTaken = 1'b0;
  logic [2:0] condSel = '0;
  logic [1:0] aSel = '0;
  logic [31:0] stackTop = '0, bOperand = '0, thisPc = '0;
  logic [7:0] alpha = '0, beta = '0;
  logic resValid, taken, redirect;
  logic [1:0] penalty, stackDelta;
  logic [31:0] target;
  logic [CW-1:0] goodJumps, badJumps, goodFalls, badFalls;

  int testCnt = 0, failCnt = 0, cyc = 0;
  int mGJ = 0, mBJ = 0, mGF = 0, mBF = 0;

  always #2.5 clk = ~clk;

  branchResolver #(.CNT_W(CW)) dut_i (
    .clk, .rstN, .start, .byteCmp, .condSel, .aSel, .predictTaken,
    .stackTop, .bOperand, .alpha, .beta, .thisPc, .resValid, .taken,
    .redirect, .penalty, .target, .stackDelta, .goodJumps, .badJumps,
    .goodFalls, .badFalls
  );

  task automatic check(string tag, longint got, longint exp);
    testCnt++;
    if (got != exp) begin
      failCnt++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > 7) ? 7 : v;
  endfunction

  task automatic checkCounters(string tag);
    check({tag, " R8 goodJumps"}, goodJumps, sat(mGJ));
    check({tag, " R8 badJumps"},  badJumps,  sat(mBJ));
    check({tag, " R8 goodFalls"}, goodFalls, sat(mGF));
    check({tag, " R8 badFalls"},  badFalls,  sat(mBF));
  endtask

  task automatic fire(vec_t v);
    @(negedge clk);
    byteCmp = v.byteCmp; condSel = v.cond; aSel = v.src; predictTaken = v.pred;
    stackTop = v.top; bOperand = v.bOp; alpha = v.alpha; beta = v.beta;
    thisPc = v.pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v.pred) begin if (v.expTaken) mGJ++; else mBJ++; end
    else        begin if (v.expTaken) mBF++; else mGF++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failCnt++; testCnt++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", resValid, 0);
    check("R1 taken", taken, 0);
    check("R1 redirect", redirect, 0);
    check("R1 penalty", penalty, 0);
    check("R1 target", target, 0);
    check("R1 delta", stackDelta, 0);
    checkCounters("R1");
    rstN = 1'b1;

    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic logic expRedir = (v.expTaken != v.pred);
      automatic logic [31:0] expTgt = v.pc + {{24{v.beta[7]}}, v.beta};
      automatic logic expPop = v.byteCmp || (v.src == 2'd3);
      fire(v);
      check($sformatf("R10 valid v%0d", i), resValid, 1);
      check($sformatf("R2 R3 R4 taken v%0d", i), taken, v.expTaken);
      check($sformatf("R6 redirect v%0d", i), redirect, expRedir);
      check($sformatf("R7 penalty v%0d", i), penalty, expRedir ? 3 : 0);
      check($sformatf("R5 target v%0d", i), target, expTgt);
      check($sformatf("R11 delta v%0d", i), stackDelta, expPop ? 2'b11 : 2'b00);
      checkCounters($sformatf("v%0d", i));
    end

    // R10: result holds and valid drops when idle, even with inputs changing
    @(negedge clk);
    stackTop = 32'd1; bOperand = 32'd9; condSel = 3'd0; beta = 8'h55;
    @(negedge clk);
    check("R10 valid low", resValid, 0);
    check("R10 taken held", taken, 1);
    check("R10 target held", target, 32'hFFFFFF80);
    checkCounters("R10 idle");

    // R9: saturation of good-jump counter
    for (int k = 0; k < 6; k++)
      fire('{1'b0, 3'd0, 2'd0, 1'b1, 32'd0, 32'd0, 8'h00, 8'h00, 32'd0, 1'b1});
    check("R9 goodJumps saturated", goodJumps, 7);
    checkCounters("R9");

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule